// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host port and an asynchronous static RAM array built from four byte-wide lanes. The lanes share one 17-bit address bus and one output enable. Each lane has its own active-low chip select and write enable. The host presents one request at a time: address, write data, byte enables, a write flag and an organisation code. The controller answers with a one-cycle completion pulse, and for reads it returns the data in the same cycle. On the memory side it drives the address and strobes and the outgoing data, and it gives an enable for the external tri-state data driver.

Every memory timing limit is an elaboration parameter in nanoseconds, next to a clock-period parameter. The phase lengths in cycles are derived from them by rounding up, so one netlist can serve any speed grade. The organisation code selects whole-word access, half-word access or byte access. Narrow accesses reach the array by asserting only the selects of the addressed lanes. Write data is replicated across the lanes, and read data is picked from the addressed lanes.

Top module: `sramc_top`

## Requirements
- R1: After reset, and whenever idle, all four chip selects, all write enables and the output enable are high, the data driver is off, `done` is low and `reqReady` is high.
- R2: A read holds the address, the selects of the addressed lanes and the output enable low, with every write enable high, for RD_CYC cycles. RD_CYC is the ceiling of the largest of the read cycle, address access and output-enable times divided by the clock period (9 at default parameters). The data is sampled at the end of that window and is returned with a one-cycle `done` pulse in the next cycle.
- R3: A write runs a setup phase with write enable high, then a write-enable-low pulse, then a hold phase, with the address constant and the selects low throughout. At default parameters the phases last 1, 7 and 1 cycles. The pulse covers the pulse width, and the setup plus the pulse covers the data-valid and select/address-to-end times. The three phases together cover the write cycle time. `done` pulses in the cycle after the hold phase, and that cycle is idle.
- R4: The data driver is enabled for the whole of a write (setup, pulse and hold) and never while output enable is low.
- R5: With organisation code 0 (32-bit), the array address is the host address, all four selects are asserted, a write asserts write enable only on lanes whose `reqBe` bit is set, and a read returns all 32 bits. Code 3 behaves like code 0.
- R6: With code 1 (16-bit), the array address is the host address shifted right by one. Host address bit 0 = 0 selects lanes 0–1 and bit 0 = 1 selects lanes 2–3. Write data bits 15:0 go to both halves of the bus. A read returns the selected half in bits 15:0, with bits 31:16 zero.
- R7: With code 2 (8-bit), the array address is the host address shifted right by two, and host address bits 1:0 select exactly one lane. Write data bits 7:0 go to every lane. A read returns the selected byte in bits 7:0, with the rest zero.
- R8: After every read the controller stays busy for HZ_CYC cycles, the ceiling of the 25 ns release time over the clock period (4 at default parameters). During those cycles the selects and output enable are high and the driver is off. Only then does it accept the next request.
- R9: A request is accepted only on a cycle where `reqReady` is high. While busy, `reqReady` is low and changes to the request inputs have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Host address, in units of the selected organisation |
| reqWdata | input | 32 | Write data, right-aligned for narrow modes |
| reqBe | input | 4 | Byte enables, used in 32-bit mode |
| orgMode | input | 2 | 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 32-bit |
| reqReady | output | 1 | Controller idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read data, valid with `done` after a read |
| memAddr | output | 17 | Array address |
| memCsN | output | 4 | Per-lane chip selects, active low |
| memWeN | output | 4 | Per-lane write enables, active low |
| memOeN | output | 1 | Shared output enable, active low |
| memDout | output | 32 | Data toward the array |
| memDoutEn | output | 1 | Enable for the external data driver |
| memDin | input | 32 | Data from the array |

## Verification
The hardest situation to reach from the ports is a write that starts right after a read, with lanes from different organisations merging into the same array word. The bus release window and the lane masking then meet. The stimulus issues each next request on the first cycle `reqReady` returns. It writes bytes, half-words and masked words onto one array address, then reads that word back in 32-bit mode. One access also keeps `reqValid` high with changing address and data while the controller is busy, to show that the latched request is what reaches the pins.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [1:0] {
    ORG_X32 = 2'd0,
    ORG_X16 = 2'd1,
    ORG_X8  = 2'd2,
    ORG_ALT = 2'd3
  } org_e;

  // Strobes from the sequencer to the datapath and pins
  typedef struct packed {
    logic load;     // latch request fields
    logic cs;       // selects active on addressed lanes
    logic oe;       // output enable active
    logic we;       // write pulse active
    logic drive;    // data driver on
    logic capture;  // sample read data
  } strobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int T_RC   = 70,
  parameter int T_AA   = 70,
  parameter int T_OE   = 35,
  parameter int T_WC   = 70,
  parameter int T_CW   = 60,
  parameter int T_AW   = 60,
  parameter int T_DW   = 30,
  parameter int T_WP   = 50,
  parameter int T_AS   = 5,
  parameter int T_AH   = 5,
  parameter int T_HZ   = 25
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    done,
  output strobe_t st
);

  localparam int RD_CYC = maxInt(maxInt(nsToCyc(T_RC, CLK_NS), nsToCyc(T_AA, CLK_NS)),
                                 nsToCyc(T_OE, CLK_NS));
  localparam int AS_CYC = nsToCyc(T_AS, CLK_NS);
  localparam int WP_CYC = maxInt(maxInt(nsToCyc(T_WP, CLK_NS), nsToCyc(T_DW, CLK_NS) - AS_CYC),
                                 maxInt(nsToCyc(T_CW, CLK_NS), nsToCyc(T_AW, CLK_NS)) - AS_CYC);
  localparam int WC_CYC = nsToCyc(T_WC, CLK_NS);
  localparam int AH_CYC = maxInt(nsToCyc(T_AH, CLK_NS), WC_CYC - AS_CYC - WP_CYC);
  localparam int HZ_CYC = nsToCyc(T_HZ, CLK_NS);
  localparam int MAXC   = maxInt(maxInt(RD_CYC, HZ_CYC), maxInt(maxInt(AS_CYC, WP_CYC), AH_CYC));
  localparam int CNT_W  = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WSET, S_WPUL, S_WHLD} state_e;

  state_e state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;
  logic phaseLast;

  always_comb begin
    unique case (state)
      S_READ:  lastVal = CNT_W'(RD_CYC - 1);
      S_TURN:  lastVal = CNT_W'(HZ_CYC - 1);
      S_WSET:  lastVal = CNT_W'(AS_CYC - 1);
      S_WPUL:  lastVal = CNT_W'(WP_CYC - 1);
      S_WHLD:  lastVal = CNT_W'(AH_CYC - 1);
      default: lastVal = '0;
    endcase
  end
  assign phaseLast = (cnt == lastVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        cnt <= '0;
        if (reqValid) state <= reqWrite ? S_WSET : S_READ;
      end else if (phaseLast) begin
        cnt <= '0;
        unique case (state)
          S_READ: begin state <= S_TURN; done <= 1'b1; end
          S_TURN: state <= S_IDLE;
          S_WSET: state <= S_WPUL;
          S_WPUL: state <= S_WHLD;
          S_WHLD: begin state <= S_IDLE; done <= 1'b1; end
          default: state <= S_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign reqReady = (state == S_IDLE);

  always_comb begin
    st.load    = (state == S_IDLE) && reqValid;
    st.cs      = (state == S_READ) || (state == S_WSET) || (state == S_WPUL) || (state == S_WHLD);
    st.oe      = (state == S_READ);
    st.we      = (state == S_WPUL);
    st.drive   = (state == S_WSET) || (state == S_WPUL) || (state == S_WHLD);
    st.capture = (state == S_READ) && phaseLast;
  end

  // R2: completion is a single-cycle pulse
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done held longer than one cycle");

  // R9: accepting a request makes the controller busy
  p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady) else $error("ready stayed high after accept");

  // R8: end of a read enters the release window with driver off
  p_turn_after_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(st.oe) |-> (state == S_TURN && !st.drive && !reqReady))
    else $error("no release window after read");

endmodule

// File: rtl/sramc_data.sv
module sramc_data
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANE_W = 8,
  localparam int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W,
  localparam int HADDR_W = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [HADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [LANES-1:0]   reqBe,
  input  logic [1:0]         orgMode,
  input  logic [DATA_W-1:0]  memDin,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [LANES-1:0]   laneSel,
  output logic [LANES-1:0]   laneWr,
  output logic [DATA_W-1:0]  memDout,
  output logic [DATA_W-1:0]  rdData
);

  logic [HADDR_W-1:0] aReg;
  logic [DATA_W-1:0]  wReg;
  logic [LANES-1:0]   beReg;
  org_e               modeReg;
  logic [LANE_W-1:0]  byteSel;
  logic [DATA_W-1:0]  rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg    <= '0;
      wReg    <= '0;
      beReg   <= '0;
      modeReg <= ORG_X32;
      rdData  <= '0;
    end else begin
      if (st.load) begin
        aReg    <= reqAddr;
        wReg    <= reqWdata;
        beReg   <= reqBe;
        modeReg <= org_e'(orgMode);
      end
      if (st.capture) rdData <= rdNext;
    end
  end

  always_comb begin
    unique case (modeReg)
      ORG_X16: begin
        memAddr = aReg[ADDR_W:1];
        laneSel = aReg[0] ? 4'b1100 : 4'b0011;
        laneWr  = laneSel;
        memDout = {2{wReg[2*LANE_W-1:0]}};
      end
      ORG_X8: begin
        memAddr = aReg[ADDR_W+1:2];
        laneSel = 4'b0001 << aReg[1:0];
        laneWr  = laneSel;
        memDout = {LANES{wReg[LANE_W-1:0]}};
      end
      default: begin
        memAddr = aReg[ADDR_W-1:0];
        laneSel = '1;
        laneWr  = beReg;
        memDout = wReg;
      end
    endcase
  end

  always_comb begin
    byteSel = '0;
    for (int l = 0; l < LANES; l++)
      if (aReg[1:0] == 2'(l)) byteSel = memDin[l*LANE_W +: LANE_W];
  end

  always_comb begin
    unique case (modeReg)
      ORG_X16: rdNext = {{(DATA_W/2){1'b0}},
                         aReg[0] ? memDin[DATA_W-1:DATA_W/2] : memDin[DATA_W/2-1:0]};
      ORG_X8:  rdNext = {{(DATA_W-LANE_W){1'b0}}, byteSel};
      default: rdNext = memDin;
    endcase
  end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANE_W = 8,
  parameter int CLK_NS = 8,
  parameter int T_RC   = 70,
  parameter int T_AA   = 70,
  parameter int T_OE   = 35,
  parameter int T_WC   = 70,
  parameter int T_CW   = 60,
  parameter int T_AW   = 60,
  parameter int T_DW   = 30,
  parameter int T_WP   = 50,
  parameter int T_AS   = 5,
  parameter int T_AH   = 5,
  parameter int T_HZ   = 25,
  localparam int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W,
  localparam int HADDR_W = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [HADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [LANES-1:0]   reqBe,
  input  logic [1:0]         orgMode,
  output logic               reqReady,
  output logic               done,
  output logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [LANES-1:0]   memCsN,
  output logic [LANES-1:0]   memWeN,
  output logic               memOeN,
  output logic [DATA_W-1:0]  memDout,
  output logic               memDoutEn,
  input  logic [DATA_W-1:0]  memDin
);

  strobe_t st;
  logic [LANES-1:0] laneSel;
  logic [LANES-1:0] laneWr;

  sramc_ctrl #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE), .T_WC(T_WC),
    .T_CW(T_CW), .T_AW(T_AW), .T_DW(T_DW), .T_WP(T_WP), .T_AS(T_AS),
    .T_AH(T_AH), .T_HZ(T_HZ)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .done(done), .st(st)
  );

  sramc_data #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .orgMode(orgMode), .memDin(memDin), .memAddr(memAddr),
    .laneSel(laneSel), .laneWr(laneWr), .memDout(memDout), .rdData(rdData)
  );

  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign memCsN[l] = ~(laneSel[l] & st.cs);
    assign memWeN[l] = ~(laneWr[l] & st.we);
  end
  assign memOeN    = ~st.oe;
  assign memDoutEn = st.drive;

  // R3: a lane is never write-strobed without its select
  p_we_within_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~memWeN & memCsN) == '0)) else $error("write enable outside select");

  // R3: address constant across consecutive driven write cycles
  p_addr_stable_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memAddr)) else $error("address moved in write");

  // R4: never drive the bus while the array may output
  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memDoutEn && !memOeN)) else $error("driver on with output enable low");

endmodule

// File: tb/tb_sramc_top.sv
module tb_sramc_top;

  localparam int CLKP = 8;
  // Phase lengths derived from the requirements at default timing
  localparam int RDC = (70 + CLKP - 1) / CLKP;   // 9
  localparam int ASC = 1;
  localparam int WPC = 7;
  localparam int AHC = 1;
  localparam int HZC = (25 + CLKP - 1) / CLKP;   // 4

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic [1:0]  orgMode = '0;
  logic reqReady, done, memOeN, memDoutEn;
  logic [31:0] rdData, memDout, memDin;
  logic [16:0] memAddr;
  logic [3:0]  memCsN, memWeN;

  int checks = 0;
  int errors = 0;

  logic [7:0] memArr [int];   // behavioural array
  logic [7:0] refArr [int];   // expected contents
  logic [3:0] prevWe = 4'hF;

  always #(CLKP/2) clk = ~clk;

  sramc_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .orgMode(orgMode),
    .reqReady(reqReady), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // Array model: drives lanes on read, stores on rising write enable
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      int k;
      k = int'(memAddr) * 4 + l;
      if (!memCsN[l] && !memOeN && memArr.exists(k)) memDin[l*8 +: 8] = memArr[k];
      else memDin[l*8 +: 8] = 8'h00;
    end
  end

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!prevWe[l] && memWeN[l] && !memCsN[l])
        memArr[int'(memAddr) * 4 + l] = memDout[l*8 +: 8];
    prevWe = memWeN;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic checkIdle(input string tag);
    chk(memCsN === 4'hF, tag, "cs idle", 32'(memCsN), 32'hF);
    chk(memWeN === 4'hF, tag, "we idle", 32'(memWeN), 32'hF);
    chk(memOeN === 1'b1, tag, "oe idle", 32'(memOeN), 32'h1);
    chk(memDoutEn === 1'b0, tag, "drive idle", 32'(memDoutEn), 32'h0);
    chk(reqReady === 1'b1, tag, "ready idle", 32'(reqReady), 32'h1);
    chk(done === 1'b0, tag, "done idle", 32'(done), 32'h0);
  endtask

  task automatic runOp(input bit wr, input logic [1:0] md, input int addr,
                       input logic [31:0] wd, input logic [3:0] be, input bit spam);
    int mAddr, last;
    logic [3:0] sel, wm;
    logic [31:0] dout, word, expRd;
    string lt;
    case (md)
      2'd1: begin mAddr = addr >> 1; sel = (addr & 1) ? 4'b1100 : 4'b0011; end
      2'd2: begin mAddr = addr >> 2; sel = 4'b0001 << (addr & 3); end
      default: begin mAddr = addr; sel = 4'hF; end
    endcase
    wm   = (md == 2'd1 || md == 2'd2) ? sel : be;
    dout = (md == 2'd1) ? {2{wd[15:0]}} : (md == 2'd2) ? {4{wd[7:0]}} : wd;
    lt   = (md == 2'd1) ? "R6" : (md == 2'd2) ? "R7" : "R5";
    if (wr) begin
      for (int l = 0; l < 4; l++) if (wm[l]) refArr[mAddr*4 + l] = dout[l*8 +: 8];
    end
    for (int l = 0; l < 4; l++)
      word[l*8 +: 8] = refArr.exists(mAddr*4 + l) ? refArr[mAddr*4 + l] : 8'h00;
    case (md)
      2'd1: expRd = {16'h0, (addr & 1) ? word[31:16] : word[15:0]};
      2'd2: expRd = {24'h0, word[(addr & 3)*8 +: 8]};
      default: expRd = word;
    endcase
    last = wr ? (ASC + WPC + AHC) : (RDC + HZC);

    @(negedge clk);
    chk(reqReady === 1'b1, "R9", "ready before issue", 32'(reqReady), 32'h1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = 19'(addr); reqWdata = wd;
    reqBe = be; orgMode = md;
    @(negedge clk);
    for (int j = 0; j <= last; j++) begin
      logic [3:0] eCs, eWe;
      logic eOe, eDrv, eDone, eRdy;
      string tt;
      eCs = 4'hF; eWe = 4'hF; eOe = 1'b1; eDrv = 1'b0; eDone = 1'b0; eRdy = 1'b0;
      tt = wr ? "R3" : "R2";
      if (j == last) begin
        eRdy = 1'b1; eDone = wr; tt = wr ? "R3" : "R8";
      end else if (!wr && j < RDC) begin
        eCs = ~sel; eOe = 1'b0;
      end else if (!wr) begin
        eDone = (j == RDC); tt = "R8";
      end else begin
        eCs = ~sel; eDrv = 1'b1;
        if (j >= ASC && j < ASC + WPC) eWe = ~wm;
      end
      chk(memCsN === eCs, lt, $sformatf("cs j=%0d", j), 32'(memCsN), 32'(eCs));
      chk(memWeN === eWe, tt, $sformatf("we j=%0d %s", j, lt), 32'(memWeN), 32'(eWe));
      chk(memOeN === eOe, tt, $sformatf("oe j=%0d", j), 32'(memOeN), 32'(eOe));
      chk(memDoutEn === eDrv, wr ? "R4" : "R8", $sformatf("drive j=%0d", j),
          32'(memDoutEn), 32'(eDrv));
      chk(done === eDone, tt, $sformatf("done j=%0d", j), 32'(done), 32'(eDone));
      chk(reqReady === eRdy, spam ? "R9" : tt, $sformatf("ready j=%0d", j),
          32'(reqReady), 32'(eRdy));
      if (eCs != 4'hF)
        chk(memAddr === 17'(mAddr), lt, $sformatf("addr j=%0d", j), 32'(memAddr), 32'(mAddr));
      if (eDrv)
        chk(memDout === dout, lt, $sformatf("dout j=%0d", j), memDout, dout);
      if (!wr && j == RDC)
        chk(rdData === expRd, lt, "read data", rdData, expRd);
      if (spam && j < last) begin
        reqValid = 1'b1; reqWrite = ~wr; reqAddr = 19'(addr + 3 + j);
        reqWdata = ~wd; reqBe = ~be; orgMode = md ^ 2'd1;
      end else begin
        reqValid = 1'b0;
      end
      if (j < last) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R1 actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1");          // R1: held in reset
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1");          // R1: idle after reset

    // R5: full-word write and read, then masked write merging lanes
    runOp(1, 2'd0, 5, 32'hA1B2C3D4, 4'hF, 0);
    runOp(0, 2'd0, 5, 32'h0, 4'h0, 0);
    runOp(1, 2'd0, 5, 32'h11223344, 4'b0101, 0);
    runOp(0, 2'd0, 5, 32'h0, 4'h0, 0);
    runOp(1, 2'd3, 6, 32'hCAFEF00D, 4'b1000, 0);
    runOp(0, 2'd3, 6, 32'h0, 4'h0, 0);

    // R6: half-word lanes at both halves
    runOp(1, 2'd1, 20, 32'hFFFF5A5A, 4'h0, 0);
    runOp(1, 2'd1, 21, 32'h0000BEEF, 4'h0, 0);
    runOp(0, 2'd1, 20, 32'h0, 4'h0, 0);
    runOp(0, 2'd1, 21, 32'h0, 4'h0, 0);

    // R7: every byte lane, then a word view of the same array word
    for (int b = 0; b < 4; b++) runOp(1, 2'd2, 44 + b, 32'hFFFFFF10 + 32'(b), 4'h0, 0);
    runOp(0, 2'd2, 46, 32'h0, 4'h0, 0);
    runOp(0, 2'd0, 11, 32'h0, 4'h0, 0);

    // R8: write issued the moment the release window ends
    runOp(0, 2'd0, 10, 32'h0, 4'h0, 0);
    runOp(1, 2'd0, 10, 32'h0BADCAFE, 4'b0110, 0);
    runOp(0, 2'd0, 10, 32'h0, 4'h0, 0);

    // R9: request inputs toggled while busy
    runOp(1, 2'd1, 7, 32'h00001234, 4'h0, 1);
    runOp(0, 2'd1, 7, 32'h0, 4'h0, 1);

    repeat (2) @(negedge clk);
    checkIdle("R1");
    finishRun();
  end

endmodule